// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block multiplies two signed two's-complement operands of a configurable width over several clock cycles. It recodes the multiplier one bit pair at a time. A guard bit sits below the multiplier register. On each cycle the pair formed by the multiplier's lowest bit and the guard bit picks one of three actions on the upper half of the running product: add the multiplicand, subtract it, or leave it unchanged. The joined upper half, multiplier and guard bit are then shifted right by one place, with the upper half's sign bit copied in at the top.

A client holds both operands steady for the cycle in which it raises a one-cycle start strobe. The block raises busy while it works and raises done for a single cycle when the full double-width product is ready. The product port always shows the joined running state, upper half above lower half. After the run it holds the final result until the next start is accepted. A start that arrives during a run is dropped.

Top module: `booth_mult`

## Requirements
- R1: After reset, busy and done are 0 and product is all zeros.
- R2: A start seen while busy is 0 captures both operands. One cycle later busy is 1 and product equals N zero bits above the multiplier operand: the upper half is cleared and the guard bit is 0.
- R3: Exactly N iterations run, one per clock. Busy stays high for N cycles after the accepting edge. Done is high in the cycle after the last iteration, for exactly one cycle, and busy is 0 in that cycle.
- R4: When done is high, product equals the exact 2N-bit signed product of the operands for every operand pair, including both operands at the most negative value.
- R5: Each iteration acts on the pair {multiplier LSB, guard bit}. Pair 01 adds the multiplicand to the upper half. Pair 10 subtracts it by adding its two's complement. Pairs 00 and 11 change nothing. The block then shifts {upper, lower, guard} right by one, arithmetically, and the upper half's LSB moves into the lower half's MSB.
- R6: With multiplicand +2 and multiplier −3, the final product is −6 (16'hFFFA at the default width of 8).
- R7: A start raised while busy is 1 is ignored. The run in progress finishes at its original time with the result of the original operands.
- R8: While busy is 0, product holds its value until a start is accepted, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| mcand | input | N | Signed multiplicand, sampled with an accepted start |
| mplier | input | N | Signed multiplier, sampled with an accepted start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Joined running state; the signed product when done is high |

## Verification
An accepted start at clock edge e0 shows up at the next edge: busy rises and the product port shows the cleared upper half with the multiplier. Iteration k takes effect at edge e0+k. Done and the final product are due at edge e0+N, and done falls again at e0+N+1. The bench drives inputs on falling edges and samples at the falling edge after each of those rising edges. After every iteration it compares the running product with a step model, then checks the final value, the done pulse, and that the result holds through the idle cycles that follow.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half and guard
    logic step;  // perform one recode-and-shift iteration
  } boothStrobe_t;
endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output boothStrobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busyR;
  logic          doneR;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strobe.load = start & ~busyR;
    strobe.step = busyR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      iterCnt <= '0;
    end else begin
      doneR <= 1'b0;
      if (strobe.load) begin
        busyR   <= 1'b1;
        iterCnt <= '0;
      end else if (busyR) begin
        iterCnt <= iterCnt + 1'b1;
        if (iterCnt == LAST) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;
endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  boothStrobe_t   strobe,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);
  logic [N-1:0] accR;
  logic [N-1:0] lowR;
  logic         guardR;
  logic [N-1:0] mcandR;

  // one bit wider than the accumulator so subtracting the most negative
  // multiplicand cannot wrap before the shift
  logic [N:0] accExt;
  logic [N:0] mExt;
  logic [N:0] sumExt;

  always_comb begin
    accExt = {accR[N-1], accR};
    mExt   = {mcandR[N-1], mcandR};
    unique case ({lowR[0], guardR})
      2'b01:   sumExt = accExt + mExt;
      2'b10:   sumExt = accExt + (~mExt) + 1'b1;
      default: sumExt = accExt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR   <= '0;
      lowR   <= '0;
      guardR <= 1'b0;
      mcandR <= '0;
    end else if (strobe.load) begin
      accR   <= '0;
      lowR   <= mplier;
      guardR <= 1'b0;
      mcandR <= mcand;
    end else if (strobe.step) begin
      // arithmetic right shift of {sum, low, guard}
      accR   <= sumExt[N:1];
      lowR   <= {sumExt[0], lowR[N-1:1]};
      guardR <= lowR[0];
    end
  end

  assign product = {accR, lowR};
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  boothStrobe_t strobe;

  booth_ctrl #(.N(N)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  booth_dp #(.N(N)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .mcand  (mcand),
    .mplier (mplier),
    .product(product)
  );
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int RW = $clog2(N + 2) + 1;

  logic [RW-1:0]         runCnt;
  logic signed [2*N-1:0] expProd;
  logic signed [2*N-1:0] extA;
  logic signed [2*N-1:0] extB;

  assign extA = {{N{mcand[N-1]}}, mcand};
  assign extB = {{N{mplier[N-1]}}, mplier};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      expProd <= '0;
    end else if (start && !busy) begin
      runCnt  <= '0;
      expProd <= extA * extB;
    end else if (busy) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && product == {{N{1'b0}}, $past(mplier)}); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R3
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runCnt == RW'(N)); // R3
  AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == expProd); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> busy || done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(product)); // R8
endmodule

bind booth_mult booth_mult_chk #(.N(N)) uChk (.*);

// File: tb/tb_booth_mult.sv
module tb_booth_mult;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0;
  logic [N-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  booth_mult #(.N(N)) dut (
    .clk(clk), .rstN(rstN), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*N-1:0] refMul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic signed [2*N-1:0] sa;
    logic signed [2*N-1:0] sb;
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    return sa * sb;
  endfunction

  // running {upper, lower} after k iterations, following the recoding rules
  function automatic logic [2*N-1:0] stepRef(input logic [N-1:0] a, input logic [N-1:0] b, input int k);
    logic [N-1:0] hi;
    logic [N-1:0] lo;
    logic         g;
    logic [N:0]   s;
    hi = '0; lo = b; g = 1'b0;
    for (int i = 0; i < k; i++) begin
      case ({lo[0], g})
        2'b01:   s = {hi[N-1], hi} + {a[N-1], a};
        2'b10:   s = {hi[N-1], hi} - {a[N-1], a};
        default: s = {hi[N-1], hi};
      endcase
      g  = lo[0];
      lo = {s[0], lo[N-1:1]};
      hi = s[N:1];
    end
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runMul(input logic [N-1:0] a, input logic [N-1:0] b, input bit intr);
    logic [2*N-1:0] fin;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = N'($urandom); mplier = N'($urandom);
    check(busy === 1'b1 && done === 1'b0, "R2 busy after start", {15'd0, busy}, 1);
    check(product === {{N{1'b0}}, b}, "R2 load state", product, {{N{1'b0}}, b});
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k < N) begin
        check(busy === 1'b1 && done === 1'b0, "R3 busy during run",
              {14'd0, busy, done}, 2);
        check(product === stepRef(a, b, k), "R5 iteration state", product, stepRef(a, b, k));
        if (intr && k == 2) begin
          start = 1'b1; mcand = ~a; mplier = b + 1'b1;
        end
      end else begin
        check(busy === 1'b0 && done === 1'b1, "R3 done after N iterations",
              {14'd0, busy, done}, 1);
        check(product === refMul(a, b), intr ? "R7 start while busy ignored" : "R4 final product",
              product, refMul(a, b));
      end
    end
    fin = product;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R3 done is one cycle", {14'd0, busy, done}, 0);
    mcand = N'($urandom); mplier = N'($urandom);
    @(negedge clk);
    check(product === fin, "R8 idle hold", product, fin);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2*N-1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", {14'd0, busy, done}, 0);
    check(product === '0, "R1 reset product", product, '0);
    rstN = 1'b1;
    @(negedge clk);
    held = product;
    mcand = 8'h55; mplier = 8'hAA;
    repeat (3) @(negedge clk);
    check(product === held, "R8 operands ignored when idle", product, held);

    // R6 worked case: +2 times -3
    runMul(8'd2, 8'hFD, 1'b0);
    check(product === 16'hFFFA, "R6 plus two times minus three", product, 16'hFFFA);

    runMul(8'h80, 8'h80, 1'b0);
    runMul(8'h80, 8'h7F, 1'b0);
    runMul(8'h7F, 8'h80, 1'b0);
    runMul(8'hFF, 8'hFF, 1'b0);
    runMul(8'h00, 8'h93, 1'b0);
    runMul(8'h01, 8'hFF, 1'b0);
    runMul(8'h7F, 8'h7F, 1'b0);
    runMul(8'h35, 8'hC6, 1'b1);
    runMul(8'h80, 8'h55, 1'b1);

    for (int i = 0; i < 200; i++) begin
      runMul(N'($urandom), N'($urandom), ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule